// File: doc/BRIEF.md
# Diode-Emulation Mode Controller

This block chooses, pulse by pulse, whether a synchronous buck controller runs in continuous conduction or in diode emulation. In every interval where the high-side gate drive is off, it waits out a short blanking time. After that it watches a digital phase-polarity comparator. If the comparator fires at any point in the rest of that interval, a latch records it. When the high-side drive turns on again, the latch yields one verdict for the finished pulse: negative inductor current if it fired, positive if it did not. A run of three like verdicts against the present mode flips the mode.

On entry to diode emulation the block raises a one-cycle request that steps the modulator window up, which lowers the switching frequency. In diode emulation it can also run an audio-filter timer. If no natural low-side pulse occurs for a set number of clocks, the timer forces a short low-side pulse so that the switching frequency stays out of the audible band. Two strap inputs choose forced continuous conduction, diode emulation alone, or diode emulation with the filter.

All pins are plain level control signals sampled on the clock. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `dem_mode_ctrl`

## Requirements
- R1: With `mode_dem_en`=1 and the block in continuous conduction, three consecutive negative verdicts set `dem_active` in the clock after the high-side turn-on that carries the third verdict.
- R2: In diode emulation, three consecutive positive verdicts clear `dem_active` in the clock after the high-side turn-on that carries the third verdict.
- R3: `phase_hi` is sampled only while `hs_gate`=0 and only after the first `BLANK_CYC` low cycles of that interval. A `phase_hi` pulse during blanking or while `hs_gate`=1 leaves the verdict positive.
- R4: A verdict is taken only at a rising edge of `hs_gate`. It is negative if `phase_hi` was sampled high in the preceding low interval and positive otherwise. The polarity record clears at every high-side turn-on.
- R5: A verdict that agrees with the present mode clears the run count, so a later mode change again needs three fresh consecutive opposing verdicts.
- R6: The straps are decoded as follows: `mode_dem_en`=0 forces continuous conduction with no forced pulses; `mode_dem_en`=1 with `mode_af_en`=0 gives diode emulation without the filter; both straps at 1 give diode emulation with the filter. If `mode_dem_en`=0 at a clock, `dem_active` is 0 in the next clock.
- R7: `win_step_req` is high for exactly one clock. That clock is the first clock in which `dem_active` is 1 after being 0. The request never rises on exit from diode emulation.
- R8: With the filter active, after `AF_PERIOD` counting clocks with no natural low-side pulse, `lg_force` goes high for `AF_WIDTH` clocks. It is masked low in any clock where `hs_gate`=1.
- R9: A clock with `ls_natural`=1 restarts the audio-filter count, so natural low-side pulses that come closer together than `AF_PERIOD` prevent every forced pulse.
- R10: After reset, `dem_active`, `win_step_req` and `lg_force` are 0 and the run count is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_dem_en | input | 1 | Strap: 1 allows diode emulation |
| mode_af_en | input | 1 | Strap: 1 enables the audio filter in diode emulation |
| hs_gate | input | 1 | High-side gate drive state, 1 = on |
| phase_hi | input | 1 | Phase comparator, 1 = positive phase voltage |
| ls_natural | input | 1 | 1 while the modulator drives a natural low-side pulse |
| dem_active | output | 1 | 1 = diode emulation, 0 = continuous conduction |
| win_step_req | output | 1 | One-clock window step-increase request on entry |
| lg_force | output | 1 | Forced low-side pulse from the audio filter |

## Verification
The bench puts comparator pulses inside the blanking time and while the high side is on. A design that samples too early or too broadly would count those pulses as negative current and enter diode emulation falsely. It breaks runs of two verdicts with a single agreeing pulse. A counter that fails to clear would then switch after a broken run. It drops the strap while in diode emulation to show that the exit is immediate. It spaces natural low-side pulses just inside the filter period to show that a timer which ignores them would still force pulses. A cycle model compared on every clock also catches a window-step request that lasts too long or fires on exit.

// File: rtl/dem_pkg.sv
package dem_pkg;
  typedef enum logic {POL_POS = 1'b0, POL_NEG = 1'b1} pol_e;
  typedef enum logic [1:0] {
    STRAP_CCM    = 2'd0,
    STRAP_DEM    = 2'd1,
    STRAP_DEM_AF = 2'd2
  } strap_mode_e;

  function automatic strap_mode_e decode_strap(input logic dem_en, input logic af_en);
    if (!dem_en)    return STRAP_CCM;
    else if (af_en) return STRAP_DEM_AF;
    else            return STRAP_DEM;
  endfunction
endpackage

// File: rtl/dem_pol_sampler.sv
module dem_pol_sampler
  import dem_pkg::*;
#(
  parameter int BLANK_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_gate,
  input  logic phase_hi,
  output logic verdict_vld,
  output pol_e verdict_pol
);
  localparam int BW = $clog2(BLANK_CYC + 2);
  localparam logic [BW-1:0] BLANK_LIM = BW'(BLANK_CYC);

  logic          hs_q;
  logic [BW-1:0] blank_cnt;
  logic          ph_lat;
  logic          smp_en;
  logic          hs_rise;

  assign hs_rise = hs_gate && !hs_q;
  assign smp_en  = !hs_gate && (blank_cnt == BLANK_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q      <= 1'b1;
      blank_cnt <= '0;
      ph_lat    <= 1'b0;
    end else begin
      hs_q <= hs_gate;
      if (hs_gate)                     blank_cnt <= '0;
      else if (blank_cnt != BLANK_LIM) blank_cnt <= blank_cnt + 1'b1;
      if (hs_rise)                     ph_lat <= 1'b0;
      else if (smp_en && phase_hi)     ph_lat <= 1'b1;
    end
  end

  assign verdict_vld = hs_rise;
  assign verdict_pol = ph_lat ? POL_NEG : POL_POS;
endmodule

// File: rtl/dem_mode_fsm.sv
module dem_mode_fsm
  import dem_pkg::*;
#(
  parameter int RUN_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dem_allow,
  input  logic verdict_vld,
  input  pol_e verdict_pol,
  output logic dem_active,
  output logic win_step_req
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] RUN_LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] run_cnt;
  logic          opposing;

  always_comb begin
    if (dem_active) opposing = (verdict_pol == POL_POS);
    else            opposing = (verdict_pol == POL_NEG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dem_active   <= 1'b0;
      win_step_req <= 1'b0;
      run_cnt      <= '0;
    end else begin
      win_step_req <= 1'b0;
      if (!dem_allow) begin
        dem_active <= 1'b0;
        run_cnt    <= '0;
      end else if (verdict_vld) begin
        if (!opposing) begin
          run_cnt <= '0;
        end else if (run_cnt == RUN_LAST) begin
          run_cnt      <= '0;
          dem_active   <= !dem_active;
          win_step_req <= !dem_active;
        end else begin
          run_cnt <= run_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dem_af_timer.sv
module dem_af_timer #(
  parameter int AF_PERIOD = 3500,
  parameter int AF_WIDTH  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic af_enable,
  input  logic hs_gate,
  input  logic ls_natural,
  output logic lg_force
);
  localparam int TW = $clog2(AF_PERIOD + 1);
  localparam int WW = $clog2(AF_WIDTH + 1);
  localparam logic [TW-1:0] T_LAST = TW'(AF_PERIOD - 1);
  localparam logic [WW-1:0] W_LOAD = WW'(AF_WIDTH);

  logic [TW-1:0] tmr;
  logic [WW-1:0] pw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr <= '0;
      pw  <= '0;
    end else if (!af_enable) begin
      tmr <= '0;
      pw  <= '0;
    end else begin
      if (pw != '0) pw <= pw - 1'b1;
      if (ls_natural || (pw != '0)) begin
        tmr <= '0;
      end else if (tmr == T_LAST) begin
        tmr <= '0;
        pw  <= W_LOAD;
      end else begin
        tmr <= tmr + 1'b1;
      end
    end
  end

  assign lg_force = (pw != '0) && !hs_gate;
endmodule

// File: rtl/dem_mode_ctrl.sv
module dem_mode_ctrl
  import dem_pkg::*;
#(
  parameter int BLANK_CYC = 4,
  parameter int RUN_LEN   = 3,
  parameter int AF_PERIOD = 3500,
  parameter int AF_WIDTH  = 20,
  parameter bit AF_IMPL   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_dem_en,
  input  logic mode_af_en,
  input  logic hs_gate,
  input  logic phase_hi,
  input  logic ls_natural,
  output logic dem_active,
  output logic win_step_req,
  output logic lg_force
);
  strap_mode_e strap;
  logic        verdict_vld;
  pol_e        verdict_pol;
  logic        af_on;

  assign strap = decode_strap(mode_dem_en, mode_af_en);

  dem_pol_sampler #(.BLANK_CYC(BLANK_CYC)) u_smp (
    .clk(clk), .rst_n(rst_n), .hs_gate(hs_gate), .phase_hi(phase_hi),
    .verdict_vld(verdict_vld), .verdict_pol(verdict_pol)
  );

  dem_mode_fsm #(.RUN_LEN(RUN_LEN)) u_fsm (
    .clk(clk), .rst_n(rst_n), .dem_allow(strap != STRAP_CCM),
    .verdict_vld(verdict_vld), .verdict_pol(verdict_pol),
    .dem_active(dem_active), .win_step_req(win_step_req)
  );

  assign af_on = dem_active && (strap == STRAP_DEM_AF);

  generate
    if (AF_IMPL) begin : g_af
      dem_af_timer #(.AF_PERIOD(AF_PERIOD), .AF_WIDTH(AF_WIDTH)) u_af (
        .clk(clk), .rst_n(rst_n), .af_enable(af_on), .hs_gate(hs_gate),
        .ls_natural(ls_natural), .lg_force(lg_force)
      );
    end else begin : g_no_af
      assign lg_force = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/dem_mode_ctrl_chk.sv
module dem_mode_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_dem_en,
  input logic mode_af_en,
  input logic hs_gate,
  input logic dem_active,
  input logic win_step_req,
  input logic lg_force
);
  // R7: request only alongside entry into diode emulation
  a_r7_step_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    win_step_req |-> $rose(dem_active));
  // R7: request lasts a single clock
  a_r7_step_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    win_step_req |=> !win_step_req);
  // R6: strap low forces continuous conduction next clock
  a_r6_forced_ccm: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_dem_en |=> !dem_active);
  // R6: filter strap low stops forced pulses next clock
  a_r6_af_off: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_af_en |=> !lg_force);
  // R8: forced pulse never overlaps high-side on
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    lg_force |-> !hs_gate);
  // R4: mode changes with strap held only after a high-side turn-on
  a_r4_change_on_turn_on: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_dem_en && $past(mode_dem_en) && (dem_active != $past(dem_active)))
      |-> ($past(hs_gate) && !$past(hs_gate, 2)));
endmodule

bind dem_mode_ctrl dem_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_dem_en(mode_dem_en), .mode_af_en(mode_af_en),
  .hs_gate(hs_gate), .dem_active(dem_active), .win_step_req(win_step_req),
  .lg_force(lg_force)
);

// File: tb/dem_mode_ctrl_tb.sv
`timescale 1ns/1ps
module dem_mode_ctrl_tb_top;
  localparam int B = 3;
  localparam int P = 60;
  localparam int W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dem_en = 1'b0, af_en = 1'b0, hs = 1'b1, ph = 1'b0, lsn = 1'b0;
  logic dem_o, step_o, lg_o;

  always #5 clk = ~clk;

  dem_mode_ctrl #(.BLANK_CYC(B), .RUN_LEN(3), .AF_PERIOD(P), .AF_WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_dem_en(dem_en), .mode_af_en(af_en),
    .hs_gate(hs), .phase_hi(ph), .ls_natural(lsn),
    .dem_active(dem_o), .win_step_req(step_o), .lg_force(lg_o)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int step_seen = 0, lg_cycles = 0;
  bit done = 0;

  // behavioural reference
  int m_hs_prev = 1, m_lowk = 0, m_lat = 0, m_dem = 0, m_cnt = 0, m_step = 0;
  int m_tmr = 0, m_pw = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hs_prev = 1; m_lowk = 0; m_lat = 0; m_dem = 0; m_cnt = 0;
      m_step = 0; m_tmr = 0; m_pw = 0;
    end else begin
      int rise, old_dem, old_lat, match;
      rise = (hs && !m_hs_prev) ? 1 : 0;
      old_dem = m_dem; old_lat = m_lat;
      if (m_dem == 1 && dem_en && af_en) begin
        int old_pw;
        old_pw = m_pw;
        if (old_pw > 0) m_pw = old_pw - 1;
        if (lsn || old_pw > 0) m_tmr = 0;
        else if (m_tmr == P - 1) begin m_tmr = 0; m_pw = W; end
        else m_tmr = m_tmr + 1;
      end else begin
        m_tmr = 0; m_pw = 0;
      end
      m_step = 0;
      if (!dem_en) begin
        m_dem = 0; m_cnt = 0;
      end else if (rise) begin
        match = (old_dem == 1) ? (old_lat == 0) : (old_lat == 1);
        if (!match) m_cnt = 0;
        else if (m_cnt == 2) begin
          m_cnt = 0; m_dem = 1 - old_dem; m_step = (old_dem == 0) ? 1 : 0;
        end else m_cnt = m_cnt + 1;
      end
      if (rise) m_lat = 0;
      else if (!hs && m_lowk == B && ph) m_lat = 1;
      if (hs) m_lowk = 0;
      else if (m_lowk < B) m_lowk = m_lowk + 1;
      m_hs_prev = hs ? 1 : 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int exp_lg();
    return (m_pw > 0 && !hs) ? 1 : 0;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (!done) begin
      chk(dem_o == m_dem[0], "R1/R2 dem_active", int'(dem_o), m_dem);
      chk(step_o == m_step[0], "R7 win_step_req", int'(step_o), m_step);
      chk(lg_o == exp_lg()[0], "R8 lg_force", int'(lg_o), exp_lg());
      if (step_o) step_seen++;
      if (lg_o) lg_cycles++;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  // one PWM pulse: hs on for on_c clocks, then off for off_c clocks;
  // ph high at off-index pos_k (-1 none), and optionally during the on time
  task automatic pulse(input int on_c, input int off_c, input int pos_k, input bit ph_on_high);
    hs = 1'b1; ph = ph_on_high;
    tick(on_c);
    ph = 1'b0; hs = 1'b0;
    for (int k = 0; k < off_c; k++) begin
      ph = (k == pos_k);
      tick(1);
    end
    ph = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(1);
    // R10: reset state
    chk(dem_o == 1'b0 && step_o == 1'b0 && lg_o == 1'b0, "R10 reset outputs", int'({dem_o, step_o, lg_o}), 0);

    // R6: forced continuous conduction ignores negative pulses
    for (int i = 0; i < 5; i++) pulse(4, 8, 5, 1'b0);
    pulse(4, 8, -1, 1'b0);
    chk(dem_o == 1'b0, "R6 forced CCM", int'(dem_o), 0);

    // R5: broken runs do not switch
    dem_en = 1'b1;
    pulse(4, 8, 5, 1'b0); pulse(4, 8, 5, 1'b0);
    pulse(4, 8, -1, 1'b0);
    pulse(4, 8, 5, 1'b0); pulse(4, 8, 5, 1'b0);
    pulse(4, 8, -1, 1'b0);
    chk(dem_o == 1'b0, "R5 run cleared", int'(dem_o), 0);

    // R1 and R7: three consecutive negatives enter DEM with one step request
    step_seen = 0;
    pulse(4, 8, 3, 1'b0); pulse(4, 8, 4, 1'b0); pulse(4, 8, 7, 1'b0);
    pulse(4, 8, -1, 1'b0);
    chk(dem_o == 1'b1, "R1 enter DEM", int'(dem_o), 1);
    chk(step_seen == 1, "R7 one step request", step_seen, 1);

    // R3 and R2: comparator only in blanking or high time reads positive
    pulse(4, 8, 1, 1'b1); pulse(4, 8, 2, 1'b1); pulse(4, 8, 0, 1'b1);
    pulse(4, 8, -1, 1'b0);
    chk(dem_o == 1'b0, "R2/R3 exit DEM", int'(dem_o), 0);
    chk(step_seen == 1, "R7 no step on exit", step_seen, 1);

    // R4: latch clears at turn-on: neg, pos, neg, neg must not enter
    pulse(4, 8, 5, 1'b0); pulse(4, 8, -1, 1'b0);
    pulse(4, 8, 5, 1'b0); pulse(4, 8, 5, 1'b0);
    pulse(4, 8, -1, 1'b0);
    chk(dem_o == 1'b0, "R4 latch cleared", int'(dem_o), 0);

    // R8: enter DEM with filter, then idle with no natural low-side
    af_en = 1'b1;
    pulse(4, 8, 5, 1'b0); pulse(4, 8, 5, 1'b0); pulse(4, 8, 5, 1'b0);
    hs = 1'b1; tick(2);
    lg_cycles = 0;
    hs = 1'b0; tick(3 * (P + W) + 10);
    chk(lg_cycles == 3 * W, "R8 forced pulses", lg_cycles, 3 * W);

    // R8: forced pulse masked while high side on
    hs = 1'b1; tick(P + W + 5);
    hs = 1'b0;
    chk(dem_o == 1'b1, "R8 still DEM", int'(dem_o), 1);

    // R9: natural low-side pulses inside the period stop forced pulses
    lg_cycles = 0;
    for (int i = 0; i < 6; i++) begin
      lsn = 1'b1; tick(1); lsn = 1'b0; tick(P - 5);
    end
    chk(lg_cycles == 0, "R9 timer restarts", lg_cycles, 0);

    // R6: filter strap off stops forced pulses
    af_en = 1'b0; lg_cycles = 0;
    tick(2 * P);
    chk(lg_cycles == 0, "R6 filter off", lg_cycles, 0);

    // R6: dropping the DEM strap exits at once
    dem_en = 1'b0; tick(1);
    chk(dem_o == 1'b0, "R6 strap exit", int'(dem_o), 0);
    tick(3);
    finish_run();
  end

  initial begin
    #1500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end
endmodule